// File: doc/BRIEF.md
# CPU Reset Source Classifier

This block watches every condition that can force a small RISC core back to its entry point and decides, cycle by cycle, whether a power-on reset or a manual reset is in effect. Two input pins decide the pin-driven case: an active-low reset pin and a mode pin whose level picks the reset type while the reset pin is held low. Two internal events can also force a manual reset. The first is a general exception taken while the status register's block bit is set, except when that exception is a user break. The second is a watchdog overflow, when the watchdog is configured both as a timer and as a reset source.

Each cycle the block registers a reset kind, a peripheral-reset strobe, the exception event code, the vector base and the initial status-register image. A reset kind and the initial values it implies always appear at the outputs in the same cycle. When the strobe drops, the block issues a one-cycle program-counter load with the common entry address. The core, and every peripheral that has to tell the two reset flavours apart, take their cues from these outputs.

Top module: `rstc_top`

## Requirements
- R1: With the reset pin low and the mode pin high at a clock edge, `rst_kind_o` reads 2'b01 (power-on) in the cycle that follows.
- R2: With the reset pin low and the mode pin low at a clock edge, `rst_kind_o` reads 2'b10 (manual) in the cycle that follows.
- R3: A general exception request with the block bit at 1 and the break flag at 0 gives a manual reset (2'b10) in the next cycle. If the break flag is 1, or the block bit is 0, the request gives no reset and `rst_kind_o` stays 2'b00.
- R4: A watchdog overflow gives a manual reset in the next cycle only when the timer-mode bit and the reset-select bit are both 1. With either bit at 0 the overflow has no effect.
- R5: If a power-on condition and any manual source occur in the same cycle, the result is power-on (2'b01).
- R6: `evt_code_o` is loaded with 12'h020 for a manual reset and with 12'h000 for a power-on reset. The load happens in the same cycle as `rst_kind_o`, and the value is held unchanged while no reset is active.
- R7: During any reset, `vbase_o` reads 32'h0000_0000 and `sr_init_o` reads 32'h7000_00F0. In that image bit 30 (privileged mode), bit 29 (register bank) and bit 28 (block) are 1, bit 15 (FPU disable) is 0, bits 7:4 (interrupt mask) are 4'b1111, and all other bits are 0. Both values are held after the reset ends.
- R8: `periph_rst_o` is high exactly in the cycles where `rst_kind_o` is not 2'b00. It therefore stays high for as long as the reset pin is held low.
- R9: `pc_load_o` pulses for one cycle in the first cycle where `periph_rst_o` is low after having been high, and `pc_value_o` then reads 32'hA000_0000.
- R10: While `rst_ni` is low, `rst_kind_o` is 2'b00, and `periph_rst_o`, `pc_load_o`, `evt_code_o` and `sr_init_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of this block's flops |
| pin_rst_ni | input | 1 | External reset pin, active low |
| pin_mode_i | input | 1 | Reset mode pin: high selects power-on, low selects manual |
| sr_block_i | input | 1 | Current status-register block bit |
| exc_req_i | input | 1 | General exception request |
| exc_brk_i | input | 1 | Exception is a user break |
| wdt_ovf_i | input | 1 | Watchdog overflow event |
| wdt_timer_mode_i | input | 1 | Watchdog configured in timer mode |
| wdt_rst_sel_i | input | 1 | Watchdog overflow configured as a reset source |
| rst_kind_o | output | 2 | 00 none, 01 power-on, 10 manual |
| periph_rst_o | output | 1 | CPU and peripheral reset strobe |
| evt_code_o | output | 12 | Exception event code |
| vbase_o | output | 32 | Initial vector base |
| sr_init_o | output | 32 | Initial status-register image |
| pc_load_o | output | 1 | One-cycle program-counter load |
| pc_value_o | output | 32 | Program-counter value to load |

## Verification
The bench aims at three risks. The first is priority: a pin-driven power-on that coincides with an exception and a watchdog overflow has to stay power-on, and a design that ranked the sources the wrong way would report manual together with code 0x020. The second is the set of exclusions. A user-break exception, an exception taken while the block bit is clear, and an overflow with only one of the two watchdog bits set must all leave the outputs quiet; a decoder that left out a term would report a spurious manual reset. The third is timing. A held pin must keep the strobe high without a program-counter load, the load must come exactly in the cycle the strobe drops, and the event code must keep its last value between resets. A design that loaded the counter early, repeated the pulse, or cleared the code would show a wrong value on those exact cycles.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        RK_NONE   = 2'b00,
        RK_POWER  = 2'b01,
        RK_MANUAL = 2'b10
    } rst_kind_e;

    // status register bit positions consumed by the core
    localparam int unsigned SR_MD_BIT = 30;
    localparam int unsigned SR_RB_BIT = 29;
    localparam int unsigned SR_BL_BIT = 28;
    localparam int unsigned SR_FD_BIT = 15;
    localparam int unsigned SR_IM_LSB = 4;
    localparam int unsigned SR_IM_W   = 4;

    // manual-reset source indices
    localparam int unsigned MSRC_PIN = 0;
    localparam int unsigned MSRC_EXC = 1;
    localparam int unsigned MSRC_WDT = 2;
    localparam int unsigned MSRC_N   = 3;

endpackage

// File: rtl/rstc_src_detect.sv
module rstc_src_detect
    import rstc_pkg::*;
(
    input  logic              pin_rst_ni,
    input  logic              pin_mode_i,
    input  logic              sr_block_i,
    input  logic              exc_req_i,
    input  logic              exc_brk_i,
    input  logic              wdt_ovf_i,
    input  logic              wdt_timer_mode_i,
    input  logic              wdt_rst_sel_i,
    output logic              por_req_o,
    output logic [MSRC_N-1:0] man_req_o
);

    logic pin_low;

    always_comb begin
        pin_low             = ~pin_rst_ni;
        por_req_o           = pin_low & pin_mode_i;
        man_req_o           = '0;
        man_req_o[MSRC_PIN] = pin_low & ~pin_mode_i;
        man_req_o[MSRC_EXC] = exc_req_i & sr_block_i & ~exc_brk_i;
        man_req_o[MSRC_WDT] = wdt_ovf_i & wdt_timer_mode_i & wdt_rst_sel_i;
    end

endmodule

// File: rtl/rstc_arbiter.sv
module rstc_arbiter
    import rstc_pkg::*;
#(
    parameter int unsigned N_MAN = 3
) (
    input  logic             por_req_i,
    input  logic [N_MAN-1:0] man_req_i,
    output rst_kind_e        kind_o
);

    logic any_man;

    always_comb begin
        any_man = |man_req_i;
        if (por_req_i) begin
            kind_o = RK_POWER;
        end else if (any_man) begin
            kind_o = RK_MANUAL;
        end else begin
            kind_o = RK_NONE;
        end
    end

endmodule

// File: rtl/rstc_init_values.sv
module rstc_init_values
    import rstc_pkg::*;
#(
    parameter int unsigned          XLEN     = 32,
    parameter int unsigned          EVT_W    = 12,
    parameter logic [EVT_W-1:0]     POR_CODE = 12'h000,
    parameter logic [EVT_W-1:0]     MAN_CODE = 12'h020
) (
    input  rst_kind_e         kind_i,
    output logic [EVT_W-1:0]  evt_o,
    output logic [XLEN-1:0]   vbase_o,
    output logic [XLEN-1:0]   sr_o
);

    logic [XLEN-1:0] sr_img;

    generate
        for (genvar b = 0; b < XLEN; b++) begin : g_sr_bit
            if (b == SR_MD_BIT || b == SR_RB_BIT || b == SR_BL_BIT) begin : g_one
                assign sr_img[b] = 1'b1;
            end else if (b >= SR_IM_LSB && b < SR_IM_LSB + SR_IM_W) begin : g_mask
                assign sr_img[b] = 1'b1;
            end else begin : g_zero
                assign sr_img[b] = 1'b0;
            end
        end
    endgenerate

    always_comb begin
        vbase_o = '0;
        sr_o    = sr_img;
        evt_o   = (kind_i == RK_POWER) ? POR_CODE : MAN_CODE;
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned          XLEN     = 32,
    parameter int unsigned          EVT_W    = 12,
    parameter logic [EVT_W-1:0]     POR_CODE = 12'h000,
    parameter logic [EVT_W-1:0]     MAN_CODE = 12'h020,
    parameter logic [31:0]          ENTRY_PC = 32'hA000_0000
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             pin_rst_ni,
    input  logic             pin_mode_i,
    input  logic             sr_block_i,
    input  logic             exc_req_i,
    input  logic             exc_brk_i,
    input  logic             wdt_ovf_i,
    input  logic             wdt_timer_mode_i,
    input  logic             wdt_rst_sel_i,
    output logic [1:0]       rst_kind_o,
    output logic             periph_rst_o,
    output logic [EVT_W-1:0] evt_code_o,
    output logic [XLEN-1:0]  vbase_o,
    output logic [XLEN-1:0]  sr_init_o,
    output logic             pc_load_o,
    output logic [XLEN-1:0]  pc_value_o
);

    localparam logic [XLEN-1:0] ENTRY_X = XLEN'(ENTRY_PC);

    typedef struct packed {
        rst_kind_e        kind;
        logic             strobe;
        logic [EVT_W-1:0] evt;
        logic [XLEN-1:0]  vbase;
        logic [XLEN-1:0]  sr;
        logic             pc_load;
        logic [XLEN-1:0]  pc;
    } state_t;

    state_t state_d, state_q;

    logic              por_req;
    logic [MSRC_N-1:0] man_req;
    rst_kind_e         kind_now;
    logic [EVT_W-1:0]  evt_new;
    logic [XLEN-1:0]   vbase_new;
    logic [XLEN-1:0]   sr_new;

    rstc_src_detect u_detect (
        .pin_rst_ni       (pin_rst_ni),
        .pin_mode_i       (pin_mode_i),
        .sr_block_i       (sr_block_i),
        .exc_req_i        (exc_req_i),
        .exc_brk_i        (exc_brk_i),
        .wdt_ovf_i        (wdt_ovf_i),
        .wdt_timer_mode_i (wdt_timer_mode_i),
        .wdt_rst_sel_i    (wdt_rst_sel_i),
        .por_req_o        (por_req),
        .man_req_o        (man_req)
    );

    rstc_arbiter #(
        .N_MAN (MSRC_N)
    ) u_arb (
        .por_req_i (por_req),
        .man_req_i (man_req),
        .kind_o    (kind_now)
    );

    rstc_init_values #(
        .XLEN     (XLEN),
        .EVT_W    (EVT_W),
        .POR_CODE (POR_CODE),
        .MAN_CODE (MAN_CODE)
    ) u_init (
        .kind_i  (kind_now),
        .evt_o   (evt_new),
        .vbase_o (vbase_new),
        .sr_o    (sr_new)
    );

    always_comb begin
        state_d         = state_q;
        state_d.kind    = kind_now;
        state_d.strobe  = (kind_now != RK_NONE);
        state_d.pc_load = state_q.strobe & (kind_now == RK_NONE);
        if (kind_now != RK_NONE) begin
            state_d.evt   = evt_new;
            state_d.vbase = vbase_new;
            state_d.sr    = sr_new;
        end
        if (state_d.pc_load) begin
            state_d.pc = ENTRY_X;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '{kind: RK_NONE, strobe: 1'b0, evt: '0, vbase: '0,
                         sr: '0, pc_load: 1'b0, pc: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign rst_kind_o   = state_q.kind;
    assign periph_rst_o = state_q.strobe;
    assign evt_code_o   = state_q.evt;
    assign vbase_o      = state_q.vbase;
    assign sr_init_o    = state_q.sr;
    assign pc_load_o    = state_q.pc_load;
    assign pc_value_o   = state_q.pc;

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int unsigned          XLEN     = 32,
    parameter int unsigned          EVT_W    = 12,
    parameter logic [EVT_W-1:0]     POR_CODE = 12'h000,
    parameter logic [EVT_W-1:0]     MAN_CODE = 12'h020,
    parameter logic [31:0]          ENTRY_PC = 32'hA000_0000
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pin_rst_ni,
    input logic             pin_mode_i,
    input logic             sr_block_i,
    input logic             exc_req_i,
    input logic             exc_brk_i,
    input logic             wdt_ovf_i,
    input logic             wdt_timer_mode_i,
    input logic             wdt_rst_sel_i,
    input logic [1:0]       rst_kind_o,
    input logic             periph_rst_o,
    input logic [EVT_W-1:0] evt_code_o,
    input logic [XLEN-1:0]  vbase_o,
    input logic [XLEN-1:0]  sr_init_o,
    input logic             pc_load_o,
    input logic [XLEN-1:0]  pc_value_o
);

    assert_por_pin_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_rst_ni && pin_mode_i) |=> (rst_kind_o == 2'b01));

    assert_man_pin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pin_rst_ni && !pin_mode_i) |=> (rst_kind_o == 2'b10));

    assert_exc_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_rst_ni && exc_req_i && sr_block_i && !exc_brk_i) |=> (rst_kind_o == 2'b10));

    assert_wdt_reset_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_rst_ni && wdt_ovf_i && wdt_timer_mode_i && wdt_rst_sel_i) |=> (rst_kind_o == 2'b10));

    assert_evt_code_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_kind_o == 2'b10) |-> (evt_code_o == MAN_CODE));

    assert_evt_por_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_kind_o == 2'b01) |-> (evt_code_o == POR_CODE));

    assert_vbase_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        periph_rst_o |-> (vbase_o == '0 && sr_init_o[30:28] == 3'b111 && !sr_init_o[15]));

    assert_strobe_kind_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        periph_rst_o |-> (rst_kind_o != 2'b00));

    assert_pc_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_load_o |=> !pc_load_o);

    assert_pc_entry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pc_load_o |-> (pc_value_o == XLEN'(ENTRY_PC) && !periph_rst_o));

endmodule

bind rstc_top rstc_checker #(
    .XLEN     (XLEN),
    .EVT_W    (EVT_W),
    .POR_CODE (POR_CODE),
    .MAN_CODE (MAN_CODE),
    .ENTRY_PC (ENTRY_PC)
) u_rstc_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .pin_rst_ni       (pin_rst_ni),
    .pin_mode_i       (pin_mode_i),
    .sr_block_i       (sr_block_i),
    .exc_req_i        (exc_req_i),
    .exc_brk_i        (exc_brk_i),
    .wdt_ovf_i        (wdt_ovf_i),
    .wdt_timer_mode_i (wdt_timer_mode_i),
    .wdt_rst_sel_i    (wdt_rst_sel_i),
    .rst_kind_o       (rst_kind_o),
    .periph_rst_o     (periph_rst_o),
    .evt_code_o       (evt_code_o),
    .vbase_o          (vbase_o),
    .sr_init_o        (sr_init_o),
    .pc_load_o        (pc_load_o),
    .pc_value_o       (pc_value_o)
);

// File: tb/rstc_top_tb_top.sv
`timescale 1ns/1ps
module rstc_top_tb_top;

    localparam logic [31:0] SR_EXP = 32'h7000_00F0;
    localparam logic [31:0] PC_EXP = 32'hA000_0000;

    typedef struct {
        logic [1:0]  kind;
        logic        strobe;
        logic [11:0] evt;
        logic [31:0] vbase;
        logic [31:0] sr;
        logic        pcl;
        logic [31:0] pc;
        string       tag;
        string       req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_n = 1'b1, mode = 1'b0, bl = 1'b0, exc = 1'b0, brk = 1'b0;
    logic wdt = 1'b0, tm = 1'b0, rs = 1'b0;

    logic [1:0]  kind_o;
    logic        periph_o;
    logic [11:0] evt_o;
    logic [31:0] vbase_o, sr_o, pc_o;
    logic        pcl_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    exp_t sb_q[$];

    // model state derived from requirements only
    logic        m_prev_strobe = 1'b0;
    logic [11:0] m_evt = 12'h000;
    logic [31:0] m_vb  = 32'h0;
    logic [31:0] m_sr  = 32'h0;
    logic [31:0] m_pc  = 32'h0;

    always #4 clk = ~clk;

    rstc_top dut_i (
        .clk_i            (clk),
        .rst_ni           (rst_n),
        .pin_rst_ni       (pin_n),
        .pin_mode_i       (mode),
        .sr_block_i       (bl),
        .exc_req_i        (exc),
        .exc_brk_i        (brk),
        .wdt_ovf_i        (wdt),
        .wdt_timer_mode_i (tm),
        .wdt_rst_sel_i    (rs),
        .rst_kind_o       (kind_o),
        .periph_rst_o     (periph_o),
        .evt_code_o       (evt_o),
        .vbase_o          (vbase_o),
        .sr_init_o        (sr_o),
        .pc_load_o        (pcl_o),
        .pc_value_o       (pc_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic p_n, input logic md, input logic b,
                        input logic e, input logic k, input logic w,
                        input logic t, input logic r,
                        input string req, input string tag);
        exp_t it;
        logic [1:0] ek;
        @(negedge clk);
        pin_n = p_n; mode = md; bl = b; exc = e; brk = k; wdt = w; tm = t; rs = r;
        if (!p_n && md)                                   ek = 2'b01;
        else if ((!p_n && !md) || (e && b && !k) || (w && t && r)) ek = 2'b10;
        else                                              ek = 2'b00;
        if (ek != 2'b00) begin
            m_evt = (ek == 2'b01) ? 12'h000 : 12'h020;
            m_vb  = 32'h0;
            m_sr  = SR_EXP;
        end
        it.pcl = m_prev_strobe && (ek == 2'b00);
        if (it.pcl) m_pc = PC_EXP;
        m_prev_strobe = (ek != 2'b00);
        it.kind = ek; it.strobe = (ek != 2'b00); it.evt = m_evt;
        it.vbase = m_vb; it.sr = m_sr; it.pc = m_pc; it.tag = tag; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic idle(input string req, input string tag);
        step(1, 0, 0, 0, 0, 0, 0, 0, req, tag);
    endtask

    // monitor: compares each result shortly after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t it;
                it = sb_q.pop_front();
                chk(kind_o == it.kind, it.req, {it.tag, " kind"}, 32'(kind_o), 32'(it.kind));
                chk(periph_o == it.strobe, "R8", {it.tag, " strobe"}, 32'(periph_o), 32'(it.strobe));
                chk(evt_o == it.evt, "R6", {it.tag, " evt"}, 32'(evt_o), 32'(it.evt));
                chk(vbase_o == it.vbase && sr_o == it.sr, "R7", {it.tag, " sr"}, sr_o, it.sr);
                chk(pcl_o == it.pcl, "R9", {it.tag, " pc_load"}, 32'(pcl_o), 32'(it.pcl));
                if (it.pcl) chk(pc_o == it.pc, "R9", {it.tag, " pc"}, pc_o, it.pc);
            end
        end
    end

    initial begin
        #160000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(kind_o == 2'b00, "R10", "kind in reset", 32'(kind_o), 0);
        chk(!periph_o && !pcl_o, "R10", "strobes in reset", {30'd0, periph_o, pcl_o}, 0);
        chk(evt_o == 12'h0 && sr_o == 32'h0, "R10", "values in reset", sr_o, 0);
        rst_n = 1'b1;

        idle("R10", "idle");
        idle("R10", "idle");
        // R3: excluded exceptions
        step(1, 0, 1, 1, 1, 0, 0, 0, "R3", "break with block");
        step(1, 0, 0, 1, 0, 0, 0, 0, "R3", "exc without block");
        // R4: partially configured watchdog
        step(1, 0, 0, 0, 0, 1, 1, 0, "R4", "wdt timer only");
        step(1, 0, 0, 0, 0, 1, 0, 1, "R4", "wdt rstsel only");
        // R2: manual pin, held
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "manual pin 1");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2", "manual pin 2");
        idle("R9", "manual release");
        idle("R6", "hold after manual");
        // R1: power-on pin held three cycles
        step(0, 1, 0, 0, 0, 0, 0, 0, "R1", "por pin 1");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R1", "por pin 2");
        step(0, 1, 0, 0, 0, 0, 0, 0, "R1", "por pin 3");
        idle("R9", "por release");
        idle("R6", "hold after por");
        // R3: blocked non-break exception
        step(1, 0, 1, 1, 0, 0, 0, 0, "R3", "exc blocked");
        idle("R9", "after exc");
        // R4: fully configured watchdog
        step(1, 0, 0, 0, 0, 1, 1, 1, "R4", "wdt reset");
        idle("R9", "after wdt");
        // R5: power-on wins over simultaneous manual sources
        step(0, 1, 1, 1, 0, 1, 1, 1, "R5", "por vs manual");
        step(0, 0, 1, 1, 0, 0, 0, 0, "R2", "pin mode flips to manual");
        idle("R9", "after flip");
        idle("R10", "final idle");

        while (sb_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule